// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two N x N matrices on a square grid of multiply-accumulate cells. The result stays in place. A value that enters on the left edge moves one cell to the right on every clock, and a value that enters on the top edge moves one cell down on every clock. Each cell multiplies the pair of values passing through it and adds the product into an accumulator that the cell owns. When the run ends, the cell in row i and column j holds C[i][j] of C = A·B. Each operand is presented at the edge exactly once. After that it is reused by every cell along its row or column, so nothing is fetched a second time.

Operands are BF16 and the running sums are FP32. Products and sums below the normal range, and subnormal inputs, are flushed to +0. The accumulator truncates instead of rounding. Behaviour for NaN and infinity is not defined.

The host pulses `start` and then presents one k-slice per clock for N clocks. Inside the block, row i is delayed by i cycles and column j by j cycles, so that A[i][k] and B[k][j] arrive at cell (i,j) in the same cycle. A controller steps through the states IDLE, FEED, DRAIN and DONE:
- IDLE goes to FEED on `start`.
- FEED goes to DRAIN after the last slice.
- DRAIN goes to DONE after the last product has reached the far corner.
- DONE holds until the next `start`.
- `start` taken in any state goes to FEED and clears the accumulators.

Results are read afterwards, one word at a time, through an address port.

Top module: `sysmm_top`

## Requirements
- R1: After reset, `done` is 0 and every result word reads as 0.
- R2: The clock edge that samples `start` = 1 clears every accumulator. In the next cycle, `rd_data` is 0 at any address.
- R3: Operands are taken only in the N cycles that follow the `start` cycle. In slice cycle k (k = 0..N-1), `a_col[16i+15:16i]` carries A[i][k] and `b_row[16j+15:16j]` carries B[k][j]. Input values in any other cycle have no effect on the result.
- R4: At the end of a run, reading `rd_addr` = i*N+j returns C[i][j], the sum of A[i][k]*B[k][j] accumulated in increasing k order onto +0.
- R5: Count the first slice cycle as cycle 0. `done` is 0 in cycles 0 to 3N-3 and rises in cycle 3N-2. It stays 1 until the next `start` and is 0 in the cycle after a `start`.
- R6: While `done` is 1 and no `start` arrives, the word at a given address does not change.
- R7: A BF16 operand has its sign in bit 15, its exponent in bits 14:7 (bias 127) and its fraction in bits 6:0. An FP32 word has its sign in bit 31, its exponent in bits 30:23 and its fraction in bits 22:0. A product of two normal BF16 operands that stays inside the normal FP32 range is exact. For example, 1.0 x 2^-100 gives 0x0D800000.
- R8: The following are replaced by +0: a product with a subnormal or zero input, a product whose exponent falls below the normal range, and a sum that cancels to zero or falls below the normal range.
- R9: Addition aligns the smaller-magnitude addend to the larger one and discards the bits shifted out. The result is then cut to 24 significant bits without rounding. So 2^24 + 3 gives 0x4B800001 and 2^24 - 3 gives 0x4B7FFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears the grid and begins a run |
| a_col | input | 16*N | Left-edge operands: one BF16 word per row for the current k |
| b_row | input | 16*N | Top-edge operands: one BF16 word per column for the current k |
| done | output | 1 | High once every accumulator holds its final value |
| rd_addr | input | clog2(N*N) | Row-major index of the result word to read |
| rd_data | output | 32 | FP32 result word at `rd_addr` |

## Verification
The bench multiplies integer-valued matrices and compares the result with integer products computed in the bench. These matrices are identity, all-negative and a sweep of mixed-sign patterns. The sweep separates a correct skew from swapped indices and from a row or column that is delayed by the wrong amount. During every cycle outside the feed window, the bench drives non-zero values on both edges. This shows whether the feed window is gated. Back-to-back runs show whether the clear on `start` works, and `done` is sampled in every cycle of a run to pin down its exact latency. Hand-built operand sets cover the remaining cases:
- a subnormal input, a product that underflows, and a product that stays exact at a small exponent;
- a large value plus and minus a small one, which separates truncation from rounding and shows that the discarded alignment bits are dropped before the subtraction.

// File: rtl/sysmm_pkg.sv
`timescale 1ns/1ps
package sysmm_pkg;
    localparam int BF_W = 16;
    localparam int FP_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FEED,
        ST_DRAIN,
        ST_DONE
    } mm_state_e;
endpackage

// File: rtl/sysmm_ctrl.sv
`timescale 1ns/1ps
module sysmm_ctrl
    import sysmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic feed,
    output logic acc_en,
    output logic clr,
    output logic done
);
    localparam int CW   = $clog2(3 * N);
    localparam int LAST = 3 * N - 3;

    mm_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (start) begin
            state_nx = ST_FEED;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_FEED: begin
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CW'(LAST))     state_nx = ST_DONE;
                    else if (cnt == CW'(N-1)) state_nx = ST_DRAIN;
                end
                ST_DRAIN: begin
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CW'(LAST)) state_nx = ST_DONE;
                end
                ST_DONE: state_nx = ST_DONE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        feed   = 1'b0;
        acc_en = 1'b0;
        done   = 1'b0;
        clr    = start;
        unique case (state)
            ST_IDLE:  ;
            ST_FEED:  begin feed = 1'b1; acc_en = 1'b1; end
            ST_DRAIN: acc_en = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sysmm_bfmul.sv
`timescale 1ns/1ps
module sysmm_bfmul (
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    output logic [31:0] p_o
);
    logic [15:0] prod;
    logic [9:0]  esum;
    logic [22:0] frac;

    always_comb begin
        prod = 16'({1'b1, a_i[6:0]}) * 16'({1'b1, b_i[6:0]});
        esum = {2'b00, a_i[14:7]} + {2'b00, b_i[14:7]} + {9'b0, prod[15]} - 10'd127;
        frac = prod[15] ? {prod[14:0], 8'b0} : {prod[13:0], 9'b0};
        if (a_i[14:7] == 8'd0 || b_i[14:7] == 8'd0 || esum[9] || esum == 10'd0)
            p_o = 32'h0;
        else if (esum[8])
            p_o = {a_i[15] ^ b_i[15], 8'hFE, 23'h7FFFFF};
        else
            p_o = {a_i[15] ^ b_i[15], esum[7:0], frac};
    end
endmodule

// File: rtl/sysmm_fadd.sv
`timescale 1ns/1ps
module sysmm_fadd (
    input  logic [31:0] acc_i,
    input  logic [31:0] add_i,
    output logic [31:0] sum_o
);
    logic        swap;
    logic [31:0] big, sml;
    logic [7:0]  eb, dexp;
    logic [23:0] mb, ms, msh, diff;
    logic [24:0] sum25;
    logic [4:0]  lz;
    logic [22:0] norm;
    logic [8:0]  eres;

    always_comb begin
        swap  = add_i[30:0] > acc_i[30:0];
        big   = swap ? add_i : acc_i;
        sml   = swap ? acc_i : add_i;
        eb    = big[30:23];
        dexp  = big[30:23] - sml[30:23];
        mb    = {1'b1, big[22:0]};
        ms    = {1'b1, sml[22:0]};
        msh   = (dexp > 8'd23) ? 24'd0 : (ms >> dexp);
        sum25 = {1'b0, mb} + {1'b0, msh};
        diff  = mb - msh;
        lz    = 5'd24;
        for (int q = 0; q < 24; q++) begin
            if (diff[q]) lz = 5'(23 - q);
        end
        norm = 23'(diff << lz);
        eres = {1'b0, eb} - {4'b0, lz};

        if (acc_i[30:23] == 8'd0)
            sum_o = (add_i[30:23] == 8'd0) ? 32'h0 : add_i;
        else if (add_i[30:23] == 8'd0)
            sum_o = acc_i;
        else if (big[31] == sml[31])
            sum_o = sum25[24] ? {big[31], eb + 8'd1, sum25[23:1]}
                              : {big[31], eb, sum25[22:0]};
        else if (diff == 24'd0 || eres[8] || eres == 9'd0)
            sum_o = 32'h0;
        else
            sum_o = {big[31], eres[7:0], norm};
    end
endmodule

// File: rtl/sysmm_cell.sv
`timescale 1ns/1ps
module sysmm_cell (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        acc_en,
    input  logic [15:0] a_i,
    input  logic [15:0] b_i,
    output logic [31:0] acc_o
);
    logic [31:0] prod, nxt;

    sysmm_bfmul i_mul (.a_i(a_i), .b_i(b_i), .p_o(prod));
    sysmm_fadd  i_add (.acc_i(acc_o), .add_i(prod), .sum_o(nxt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_o <= 32'h0;
        else if (clr)    acc_o <= 32'h0;
        else if (acc_en) acc_o <= nxt;
    end
endmodule

// File: rtl/sysmm_top.sv
`timescale 1ns/1ps
module sysmm_top
    import sysmm_pkg::*;
#(
    parameter  int N  = 4,
    localparam int NN = N * N,
    localparam int AW = (NN > 1) ? $clog2(NN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*BF_W-1:0] a_col,
    input  logic [N*BF_W-1:0] b_row,
    output logic              done,
    input  logic [AW-1:0]     rd_addr,
    output logic [FP_W-1:0]   rd_data
);
    logic feed, acc_en, clr;
    logic [BF_W-1:0] a_w [N][N];
    logic [BF_W-1:0] b_w [N][N];
    logic [FP_W-1:0] accs [NN];

    sysmm_ctrl #(.N(N)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .feed(feed), .acc_en(acc_en), .clr(clr), .done(done)
    );

    // edge skew: lane i is delayed by i cycles
    for (genvar i = 0; i < N; i++) begin : g_edge
        logic [BF_W-1:0] a_g, b_g;
        assign a_g = feed ? a_col[i*BF_W +: BF_W] : '0;
        assign b_g = feed ? b_row[i*BF_W +: BF_W] : '0;
        if (i == 0) begin : g_direct
            assign a_w[0][0] = a_g;
            assign b_w[0][0] = b_g;
        end else begin : g_delay
            logic [BF_W-1:0] a_sk [i];
            logic [BF_W-1:0] b_sk [i];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n || clr) begin
                    for (int d = 0; d < i; d++) begin
                        a_sk[d] <= '0;
                        b_sk[d] <= '0;
                    end
                end else begin
                    a_sk[0] <= a_g;
                    b_sk[0] <= b_g;
                    for (int d = 1; d < i; d++) begin
                        a_sk[d] <= a_sk[d-1];
                        b_sk[d] <= b_sk[d-1];
                    end
                end
            end
            assign a_w[i][0] = a_sk[i-1];
            assign b_w[0][i] = b_sk[i-1];
        end
    end

    // cell grid with pass registers toward east and south
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            sysmm_cell i_cell (
                .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
                .a_i(a_w[i][j]), .b_i(b_w[i][j]), .acc_o(accs[i*N+j])
            );
            if (j < N - 1) begin : g_pass_a
                logic [BF_W-1:0] a_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n || clr) a_q <= '0;
                    else               a_q <= a_w[i][j];
                end
                assign a_w[i][j+1] = a_q;
            end
            if (i < N - 1) begin : g_pass_b
                logic [BF_W-1:0] b_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n || clr) b_q <= '0;
                    else               b_q <= b_w[i][j];
                end
                assign b_w[i+1][j] = b_q;
            end
        end
    end

    assign rd_data = (int'(rd_addr) < NN) ? accs[rd_addr] : '0;
endmodule

// File: rtl/sysmm_chk.sv
`timescale 1ns/1ps
module sysmm_chk #(
    parameter  int N  = 4,
    localparam int NN = N * N,
    localparam int AW = (NN > 1) ? $clog2(NN) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic [AW-1:0] rd_addr,
    input logic [31:0]   rd_data
);
    localparam int LAT = 3 * N - 2;
    localparam int SW  = $clog2(LAT + 2) + 1;

    logic [SW-1:0] since;
    logic          running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since   <= '0;
            running <= 1'b0;
        end else if (start) begin
            since   <= '0;
            running <= 1'b1;
        end else if (since != SW'(LAT + 1)) begin
            since <= since + 1'b1;
        end
    end

    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (running && since == SW'(LAT)));

    a_r5_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rd_data == 32'h0));

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && (rd_addr != $past(rd_addr) || $stable(rd_data))));
endmodule

bind sysmm_top sysmm_chk #(.N(N)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_sysmm_top.sv
`timescale 1ns/1ps
module test_sysmm_top;
    localparam int N  = 4;
    localparam int NN = N * N;
    localparam int AW = $clog2(NN);
    localparam logic [15:0] JUNK = 16'h4120;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start = 1'b0;
    logic [N*16-1:0] a_col = '0;
    logic [N*16-1:0] b_row = '0;
    logic            done;
    logic [AW-1:0]   rd_addr = '0;
    logic [31:0]     rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [15:0] am [N][N];
    logic [15:0] bm [N][N];
    logic [31:0] ex [N][N];
    int          ia [N][N];
    int          ib [N][N];

    sysmm_top #(.N(N)) i_sysmm_top (
        .clk(clk), .rst_n(rst_n), .start(start), .a_col(a_col), .b_row(b_row),
        .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bf16(input int v);
        int mag, p;
        if (v == 0) return 16'h0;
        mag = (v < 0) ? -v : v;
        p = 0;
        for (int q = 0; q < 8; q++) if ((mag >> q) & 1) p = q;
        return {v < 0, 8'(127 + p), 7'((mag << (7 - p)) - (1 << 7))};
    endfunction

    function automatic logic [31:0] to_fp32(input int v);
        int mag, p;
        if (v == 0) return 32'h0;
        mag = (v < 0) ? -v : v;
        p = 0;
        for (int q = 0; q < 24; q++) if ((mag >> q) & 1) p = q;
        return {v < 0, 8'(127 + p), 23'((mag << (23 - p)) - (1 << 23))};
    endfunction

    task automatic load_ints();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                int s;
                s = 0;
                for (int k = 0; k < N; k++) s += ia[i][k] * ib[k][j];
                am[i][j] = to_bf16(ia[i][j]);
                bm[i][j] = to_bf16(ib[i][j]);
                ex[i][j] = to_fp32(s);
            end
    endtask

    task automatic clear_mats();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                am[i][j] = 16'h0; bm[i][j] = 16'h0; ex[i][j] = 32'h0;
            end
    endtask

    task automatic run_and_check(input string req);
        @(negedge clk);
        start = 1'b1;
        a_col = {N{JUNK}};
        b_row = {N{JUNK}};
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3 * N; c++) begin
            if (c > 0) @(negedge clk);
            for (int i = 0; i < N; i++) begin
                a_col[i*16 +: 16] = (c < N) ? am[i][c] : JUNK;   // R3 window
                b_row[i*16 +: 16] = (c < N) ? bm[c][i] : JUNK;
            end
            #1;
            if (c == 0) chk("R2", "accumulator cleared in cycle 0", rd_data, 32'h0);
            chk("R5", $sformatf("done in cycle %0d", c), {31'b0, done},
                (c >= 3 * N - 2) ? 32'd1 : 32'd0);
        end
        for (int idx = 0; idx < NN; idx++) begin
            @(negedge clk);
            rd_addr = AW'(idx);
            #1;
            chk(req, $sformatf("C[%0d][%0d]", idx / N, idx % N), rd_data, ex[idx / N][idx % N]);
        end
        repeat (3) @(negedge clk);
        rd_addr = '0;
        #1;
        chk("R6", "C[0][0] held after done", rd_data, ex[0][0]);
        chk("R5", "done held", {31'b0, done}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R5 watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b1;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "done after reset", {31'b0, done}, 32'd0);
        for (int idx = 0; idx < NN; idx++) begin
            @(negedge clk);
            rd_addr = AW'(idx);
            #1;
            chk("R1", $sformatf("word %0d after reset", idx), rd_data, 32'h0);
        end

        // R4: A times identity
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ia[i][j] = ((i * 5 + j * 3 + 2) % 17) - 8;
                ib[i][j] = (i == j) ? 1 : 0;
            end
        load_ints();
        run_and_check("R4");

        // R4: negative constant matrices
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                ia[i][j] = -1;
                ib[i][j] = -(j + 1);
            end
        load_ints();
        run_and_check("R4");

        // R4: mixed-sign sweep
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    ia[i][j] = ((t * 7 + i * 5 + j * 3 + i * j * t + 3) % 17) - 8;
                    ib[i][j] = ((t * 3 + i * 11 + j * 7 + (i + j) * t + 5) % 17) - 8;
                end
            load_ints();
            run_and_check("R4");
        end

        // R7/R8: subnormal input, underflowing product, small exact products
        clear_mats();
        am[1][0] = 16'h0040;          // subnormal
        am[2][0] = 16'h0D80;          // 2^-100
        am[3][0] = 16'h3F80;          // 1.0
        bm[0][0] = 16'h0D80;          // 2^-100
        for (int j = 1; j < N; j++) bm[0][j] = 16'h4000;   // 2.0
        for (int j = 1; j < N; j++) begin
            ex[2][j] = 32'h0E000000;  // 2^-99
            ex[3][j] = 32'h40000000;  // 2.0
        end
        ex[3][0] = 32'h0D800000;      // R7 exact 2^-100
        run_and_check("R8");

        // R9: truncation when adding and subtracting a small value from 2^24
        clear_mats();
        am[0][0] = 16'h4B80; am[0][1] = 16'h4040;   // 2^24, +3
        am[1][0] = 16'h4B80; am[1][1] = 16'hC040;   // 2^24, -3
        bm[0][0] = 16'h3F80; bm[1][0] = 16'h3F80;
        ex[0][0] = 32'h4B800001;
        ex[1][0] = 32'h4B7FFFFE;
        run_and_check("R9");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule